// File: doc/BRIEF.md
# Operand Address Resolver

This block turns the operand fields of an instruction for an 8-bit accumulator machine into the location of the operand byte in internal data memory. It takes the operand mode, a 3-bit working-register index, the direct address byte and the immediate byte. It returns one of two things: an 8-bit internal RAM address, or a flag that says the operand value is the immediate byte itself. Working registers are banked. The active bank is held in a small register inside the block, and that register is loaded through a separate write strobe.

Register, direct and immediate operands resolve one cycle after the request is accepted. An indirect operand first reads the pointer register (R0 or R1 of the active bank) through a read port to the register file. The pointer value then comes out as the operand address one cycle later. While that pointer read is in flight the block drops its ready signal.

Top module: `operand_addr_resolver`

## Requirements
- R1: After reset, `res_valid` is 0, `req_ready` is 1 and the active bank is 0, so a register-mode request with index i made before any bank write resolves to address i.
- R2: Register mode (`req_mode` = 2'b00) resolves to address bank×8 + index, which always lies in 00h..1Fh. `res_is_imm` is 0 and the result is valid in the cycle after the request is accepted.
- R3: Indirect mode (`req_mode` = 2'b10) drives `ptr_rd_en` for exactly one cycle, in the cycle after acceptance. During that cycle `ptr_rd_addr` = bank×8 + `req_reg[0]`, so only R0 or R1 is read and index bits 2:1 are ignored.
- R4: In indirect mode, `res_addr` equals the byte returned on `ptr_rd_data` during the pointer-read cycle, with `res_is_imm` = 0. The result is valid two cycles after acceptance.
- R5: Immediate mode (`req_mode` = 2'b11) sets `res_is_imm` = 1, gives `res_imm` = `req_imm` and `res_addr` = 00h, and issues no pointer read. The result is valid one cycle after acceptance.
- R6: Direct mode (`req_mode` = 2'b01) sets `res_addr` = `req_direct`, unchanged for every byte value, with `res_is_imm` = 0. The result is valid one cycle after acceptance.
- R7: A cycle with `bank_we` = 1 loads `bank_sel` as the active bank. A request accepted in that same cycle still uses the previous bank, and requests accepted later use the new one.
- R8: `req_ready` is 0 during the pointer-read cycle. A request presented then is dropped and produces no result.
- R9: `res_valid` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_we | input | 1 | Load the active-bank register |
| bank_sel | input | 2 | New active bank |
| req_valid | input | 1 | Operand resolution request |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_mode | input | 2 | 00 register, 01 direct, 10 indirect, 11 immediate |
| req_reg | input | 3 | Working-register index |
| req_direct | input | 8 | Direct address byte |
| req_imm | input | 8 | Immediate byte |
| ptr_rd_en | output | 1 | Pointer register read strobe |
| ptr_rd_addr | output | 8 | Physical address of the pointer register |
| ptr_rd_data | input | 8 | Pointer value returned in the same cycle |
| res_valid | output | 1 | Result pulse |
| res_is_imm | output | 1 | Operand is the immediate byte |
| res_addr | output | 8 | Resolved internal RAM address |
| res_imm | output | 8 | Immediate operand value |

## Verification
The bench sweeps every bank and every register index in register and indirect mode, and every byte value in direct mode. A resolver that dropped or shifted the bank field would collide across banks or land above 1Fh. One that decoded the whole index for indirect mode would read R2..R7 as the pointer. The bench also places a bank write in the same cycle as a request: a design that let the new bank through early would resolve that request into the wrong bank. A request presented during the pointer-read cycle must vanish; a design that accepted it would emit an extra result or corrupt the pending pointer address.

// File: rtl/oar_pkg.sv
package oar_pkg;

  parameter int unsigned OAR_ADDR_W = 8;
  parameter int unsigned OAR_IDX_W  = 3;
  parameter int unsigned OAR_BANK_W = 2;

  typedef enum logic [1:0] {
    OP_REG = 2'b00,
    OP_DIR = 2'b01,
    OP_IND = 2'b10,
    OP_IMM = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic                  is_imm;
    logic [OAR_ADDR_W-1:0] addr;
    logic [OAR_ADDR_W-1:0] imm;
  } oar_res_t;

endpackage

// File: rtl/oar_bank_reg.sv
module oar_bank_reg #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] din,
  output logic [BANK_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= din;
    end
  end

endmodule

// File: rtl/oar_mode_decode.sv
module oar_mode_decode
  import oar_pkg::*;
#(
  parameter int unsigned ADDR_W = OAR_ADDR_W,
  parameter int unsigned IDX_W  = OAR_IDX_W,
  parameter int unsigned BANK_W = OAR_BANK_W
) (
  input  op_mode_e          mode,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] direct,
  input  logic [ADDR_W-1:0] imm,
  output oar_res_t          res,
  output logic              needs_ptr,
  output logic [ADDR_W-1:0] ptr_addr
);

  localparam int unsigned REG_SPAN_W = IDX_W + BANK_W;

  // Register address: bank field placed above the index field.
  function automatic logic [ADDR_W-1:0] reg_phys(input logic [BANK_W-1:0] b,
                                                 input logic [IDX_W-1:0]  i);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[IDX_W +: BANK_W] = b;
    r[IDX_W-1:0]       = i;
    return r;
  endfunction

  // Indirect pointer may only be R0 or R1: keep index bit 0 alone.
  function automatic logic [IDX_W-1:0] ptr_index(input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] p;
    p    = '0;
    p[0] = i[0];
    return p;
  endfunction

  generate
    if (REG_SPAN_W > ADDR_W) begin : g_bad_span
      initial $display("oar_mode_decode: register space wider than address");
    end
  endgenerate

  always_comb begin
    res       = '0;
    needs_ptr = 1'b0;
    unique case (mode)
      OP_REG: res.addr = reg_phys(bank, idx);
      OP_DIR: res.addr = direct;
      OP_IND: needs_ptr = 1'b1;
      OP_IMM: begin
        res.is_imm = 1'b1;
        res.imm    = imm;
      end
      default: res = '0;
    endcase
    ptr_addr = reg_phys(bank, ptr_index(idx));
  end

endmodule

// File: rtl/oar_seq.sv
module oar_seq
  import oar_pkg::*;
#(
  parameter int unsigned ADDR_W = OAR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  op_mode_e          mode,
  input  oar_res_t          dec_res,
  input  logic              needs_ptr,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [ADDR_W-1:0] ptr_rd_data,
  output logic              pend,
  output logic [ADDR_W-1:0] ptr_addr_q,
  output logic              res_valid,
  output oar_res_t          res_q,
  output op_mode_e          res_mode
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      ptr_addr_q <= '0;
      res_valid  <= 1'b0;
      res_q      <= '0;
      res_mode   <= OP_REG;
    end else begin
      res_valid <= 1'b0;
      if (pend) begin
        pend        <= 1'b0;
        res_valid   <= 1'b1;
        res_q       <= '0;
        res_q.addr  <= ptr_rd_data;
        res_mode    <= OP_IND;
      end else if (fire) begin
        if (needs_ptr) begin
          pend       <= 1'b1;
          ptr_addr_q <= ptr_addr;
        end else begin
          res_valid <= 1'b1;
          res_q     <= dec_res;
          res_mode  <= mode;
        end
      end
    end
  end

endmodule

// File: rtl/operand_addr_resolver.sv
module operand_addr_resolver
  import oar_pkg::*;
#(
  parameter int unsigned ADDR_W = OAR_ADDR_W,
  parameter int unsigned IDX_W  = OAR_IDX_W,
  parameter int unsigned BANK_W = OAR_BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [IDX_W-1:0]  req_reg,
  input  logic [ADDR_W-1:0] req_direct,
  input  logic [ADDR_W-1:0] req_imm,
  output logic              ptr_rd_en,
  output logic [ADDR_W-1:0] ptr_rd_addr,
  input  logic [ADDR_W-1:0] ptr_rd_data,
  output logic              res_valid,
  output logic              res_is_imm,
  output logic [ADDR_W-1:0] res_addr,
  output logic [ADDR_W-1:0] res_imm
);

  // Named internal events for the checker.
  logic              req_fire;
  logic              pend_q;
  logic [BANK_W-1:0] bank_q;
  op_mode_e          mode_e;
  op_mode_e          res_mode_q;
  oar_res_t          dec_res;
  oar_res_t          res_q;
  logic              dec_needs_ptr;
  logic [ADDR_W-1:0] dec_ptr_addr;
  logic [ADDR_W-1:0] ptr_addr_q;

  assign mode_e    = op_mode_e'(req_mode);
  assign req_ready = ~pend_q;
  assign req_fire  = req_valid & req_ready;

  oar_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bank_we),
    .din  (bank_sel),
    .q    (bank_q)
  );

  oar_mode_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_dec (
    .mode     (mode_e),
    .idx      (req_reg),
    .bank     (bank_q),
    .direct   (req_direct),
    .imm      (req_imm),
    .res      (dec_res),
    .needs_ptr(dec_needs_ptr),
    .ptr_addr (dec_ptr_addr)
  );

  oar_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (req_fire),
    .mode       (mode_e),
    .dec_res    (dec_res),
    .needs_ptr  (dec_needs_ptr),
    .ptr_addr   (dec_ptr_addr),
    .ptr_rd_data(ptr_rd_data),
    .pend       (pend_q),
    .ptr_addr_q (ptr_addr_q),
    .res_valid  (res_valid),
    .res_q      (res_q),
    .res_mode   (res_mode_q)
  );

  assign ptr_rd_en   = pend_q;
  assign ptr_rd_addr = ptr_addr_q;
  assign res_is_imm  = res_q.is_imm;
  assign res_addr    = res_q.addr;
  assign res_imm     = res_q.imm;

endmodule

// File: rtl/oar_checker.sv
module oar_checker
  import oar_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bank_we,
  input logic [1:0] bank_sel,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_mode,
  input logic [7:0] req_direct,
  input logic [7:0] req_imm,
  input logic       ptr_rd_en,
  input logic [7:0] ptr_rd_addr,
  input logic [7:0] ptr_rd_data,
  input logic       res_valid,
  input logic       res_is_imm,
  input logic [7:0] res_addr,
  input logic [7:0] res_imm,
  input logic       req_fire,
  input logic [1:0] bank_q,
  input op_mode_e   res_mode_q
);

  AST_REG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mode_q == OP_REG) |-> (res_addr[7:5] == 3'b000 && !res_is_imm)); // R2

  AST_PTR_R0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd_en |-> (ptr_rd_addr[2:1] == 2'b00 && ptr_rd_addr[7:5] == 3'b000)); // R3

  AST_IND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd_en |=> (res_valid && !res_is_imm && res_addr == $past(ptr_rd_data))); // R4

  AST_IMM_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_mode == 2'b11) |=> (res_valid && res_is_imm && res_addr == 8'h00
                                          && res_imm == $past(req_imm) && !ptr_rd_en)); // R5

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_mode == 2'b01) |=> (res_valid && res_addr == $past(req_direct))); // R6

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_q == $past(bank_sel))); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd_en |-> !req_ready); // R8

  AST_IND_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd_en |=> !ptr_rd_en); // R3

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(ptr_rd_en) && !$past(req_fire)) |-> 1'b0); // R9

  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !ptr_rd_en); // R8

endmodule

bind operand_addr_resolver oar_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_we    (bank_we),
  .bank_sel   (bank_sel),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mode   (req_mode),
  .req_direct (req_direct),
  .req_imm    (req_imm),
  .ptr_rd_en  (ptr_rd_en),
  .ptr_rd_addr(ptr_rd_addr),
  .ptr_rd_data(ptr_rd_data),
  .res_valid  (res_valid),
  .res_is_imm (res_is_imm),
  .res_addr   (res_addr),
  .res_imm    (res_imm),
  .req_fire   (req_fire),
  .bank_q     (bank_q),
  .res_mode_q (res_mode_q)
);

// File: tb/operand_addr_resolver_test.sv
`timescale 1ns/1ps
module operand_addr_resolver_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_we = 1'b0;
  logic [1:0] bank_sel = 2'd0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_mode = 2'd0;
  logic [2:0] req_reg = 3'd0;
  logic [7:0] req_direct = 8'd0;
  logic [7:0] req_imm = 8'd0;
  logic       ptr_rd_en;
  logic [7:0] ptr_rd_addr;
  logic [7:0] ptr_rd_data;
  logic       res_valid;
  logic       res_is_imm;
  logic [7:0] res_addr;
  logic [7:0] res_imm;

  logic [7:0] bmem [0:31];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign ptr_rd_data = ptr_rd_en ? bmem[ptr_rd_addr[4:0]] : 8'h00;

  operand_addr_resolver uut (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_sel(bank_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_reg(req_reg), .req_direct(req_direct), .req_imm(req_imm),
    .ptr_rd_en(ptr_rd_en), .ptr_rd_addr(ptr_rd_addr), .ptr_rd_data(ptr_rd_data),
    .res_valid(res_valid), .res_is_imm(res_is_imm), .res_addr(res_addr),
    .res_imm(res_imm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int b, input int i);
    return 8'((b * 8) + i);
  endfunction

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic issue(input logic [1:0] m, input logic [2:0] i,
                       input logic [7:0] d, input logic [7:0] im);
    req_valid = 1'b1; req_mode = m; req_reg = i; req_direct = d; req_imm = im;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_bank(input logic [1:0] b);
    bank_we = 1'b1; bank_sel = b;
    @(posedge clk);
    @(negedge clk);
    bank_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) bmem[k] = 8'((k * 37) + 11);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
    issue(2'b00, 3'd5, 8'h00, 8'h00);
    chk(res_valid && res_addr == 8'h05, "R1 default bank 0", res_addr, 5);

    // R2: register mode sweep over all banks and indices
    for (int b = 0; b < 4; b++) begin
      set_bank(2'(b));
      for (int i = 0; i < 8; i++) begin
        issue(2'b00, 3'(i), 8'hA5, 8'h3C);
        chk(res_valid && !res_is_imm && res_addr == exp_reg(b, i),
            "R2 register address", res_addr, exp_reg(b, i));
        @(negedge clk);
        chk(!res_valid, "R9 single pulse", res_valid, 0);
      end
    end

    // R3/R4: indirect sweep, all banks, all indices (bits 2:1 ignored)
    for (int b = 0; b < 4; b++) begin
      set_bank(2'(b));
      for (int i = 0; i < 8; i++) begin
        issue(2'b10, 3'(i), 8'h77, 8'h00);
        chk(ptr_rd_en && ptr_rd_addr == exp_reg(b, i % 2),
            "R3 pointer address", ptr_rd_addr, exp_reg(b, i % 2));
        chk(!res_valid, "R4 no early result", res_valid, 0);
        @(negedge clk);
        chk(res_valid && !res_is_imm && res_addr == bmem[b * 8 + (i % 2)],
            "R4 indirect result", res_addr, bmem[b * 8 + (i % 2)]);
        chk(!ptr_rd_en, "R3 single strobe", ptr_rd_en, 0);
      end
    end

    // R6: direct mode, every byte
    for (int a = 0; a < 256; a++) begin
      issue(2'b01, 3'(a), 8'(a), 8'(255 - a));
      chk(res_valid && !res_is_imm && res_addr == 8'(a), "R6 direct address", res_addr, a);
    end

    // R5: immediate mode
    for (int v = 0; v < 256; v += 17) begin
      issue(2'b11, 3'(v), 8'(v ^ 8'h5A), 8'(v));
      chk(res_valid && res_is_imm && res_imm == 8'(v) && res_addr == 8'h00 && !ptr_rd_en,
          "R5 immediate", res_imm, v);
    end

    // R7: bank write coincident with a request
    set_bank(2'd0);
    bank_we = 1'b1; bank_sel = 2'd2;
    issue(2'b00, 3'd3, 8'h00, 8'h00);
    bank_we = 1'b0;
    chk(res_valid && res_addr == 8'h03, "R7 same-cycle uses old bank", res_addr, 3);
    issue(2'b00, 3'd3, 8'h00, 8'h00);
    chk(res_valid && res_addr == 8'h13, "R7 next request uses new bank", res_addr, 8'h13);
    // bank write during indirect pointer cycle keeps captured bank
    issue(2'b10, 3'd1, 8'h00, 8'h00);
    bank_we = 1'b1; bank_sel = 2'd3;
    chk(ptr_rd_addr == 8'h11, "R7 captured bank for pointer", ptr_rd_addr, 8'h11);
    @(negedge clk);
    bank_we = 1'b0;
    chk(res_valid && res_addr == bmem[17], "R7 indirect result old bank", res_addr, bmem[17]);

    // R8: request during pointer cycle is dropped
    issue(2'b10, 3'd0, 8'h00, 8'h00);
    chk(!req_ready, "R8 not ready during pointer read", req_ready, 0);
    req_valid = 1'b1; req_mode = 2'b01; req_direct = 8'h55;
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid && res_addr == bmem[24], "R8 pending indirect completes", res_addr, bmem[24]);
    @(negedge clk);
    chk(!res_valid && !ptr_rd_en, "R8 busy request dropped", res_valid, 0);
    chk(req_ready, "R8 ready again", req_ready, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule